// File: doc/BRIEF.md
# LIN frame response engine

This block is the frame layer of a LIN node and works next to a byte UART. It takes the protected identifier that the header delivers and checks the two parity bits. It then settles the length of the response and the kind of checksum. After that it either feeds response bytes from an eight-entry buffer to the UART and appends the checksum, or it stores received bytes in that buffer and checks the checksum that closes the frame. Break and sync handling, baud measurement and bit sampling are done elsewhere.

Two protocol generations are supported. With `mode_v2_i` low, the identifier byte carries a two-bit length code and the checksum is always classic. With `mode_v2_i` high, the identifier is six bits, software supplies the length, and the checksum is enhanced. Identifiers 0x3C to 0x3F are the exception and use the classic form in either mode. Software reaches the buffer through one data port with a 3-bit index that can step on its own. The block keeps sticky error flags and reports how many bytes left before an abort.

Top module: `lin_resp_engine`

## Requirements
- R1: A header is taken on `id_valid_i`. Byte bit 6 must equal the XOR of bits 0, 1, 2 and 4. Byte bit 7 must equal the inverse of the XOR of bits 1, 3, 4 and 5. On a match, `id_ok_o` is high from the next cycle. On a mismatch, `err_flags_o[2]` is set, `id_ok_o` stays low and no response phase starts (`busy_o` low).
- R2: With `mode_v2_i`=0, the length code in byte bits 5:4 gives the response length on `resp_len_o`: code 0 or 1 gives 2, code 2 gives 4, code 3 gives 8. The length appears in the same cycle as `id_ok_o`.
- R3: With `mode_v2_i`=1, the length is `soft_len_i` when it lies in 1..8. A value of 0 or above 8 gives 8.
- R4: The checksum is an 8-bit sum in which each carry out is added back in, and the sent value is the inverse of that sum. The classic form sums the data bytes only. The enhanced form starts the sum with the protected identifier byte. The classic form applies when `mode_v2_i`=0, or when byte bits 5:0 are 0x3C..0x3F.
- R5: When `dir_tx_i` is high at the header, `tx_byte_o` shows buffer entries 0 to len-1 and then the checksum. Each byte advances on a cycle with `tx_valid_o` and `tx_ready_i` both high. `tx_ok_o` rises after the checksum byte is taken, and `busy_o` then falls.
- R6: When `dir_tx_i` is low, the bytes received on `rx_valid_i` fill buffer entries 0 to len-1, and the next byte is the checksum. On a match `rx_ok_o` is set. Otherwise `err_flags_o[1]` is set and `rx_ok_o` stays low.
- R7: A pulse on any error input during a response ends it: `tx_valid_o` and `busy_o` are low from the next cycle. `sent_cnt_o` holds the number of transmit bytes accepted before the error cycle.
- R8: `err_flags_o` bits are: [0] bit error, [1] checksum, [2] parity, [3] framing, [4] overrun, [5] sync, [6] timeout. A flag stays set until the next header, which clears the flags and also `tx_ok_o` and `rx_ok_o`. `err_o` is high while any flag is set.
- R9: `buf_idx_ld_i` loads the buffer index. `buf_rdata_o` shows the entry at the index. `buf_wr_i` writes that entry. With `buf_autoinc_i` high, each read or write strobe advances the index by one, and the index wraps from 7 to 0. With it low, the index holds.
- R10: Software buffer writes made while `busy_o` is high are ignored and do not advance the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_v2_i | input | 1 | 1: six-bit identifier, software length, enhanced checksum |
| dir_tx_i | input | 1 | Sampled at header: 1 transmit response, 0 receive |
| soft_len_i | input | 4 | Response length used in v2 mode |
| id_valid_i | input | 1 | Protected identifier byte present |
| id_byte_i | input | 8 | Protected identifier byte |
| rx_valid_i | input | 1 | Received response byte present |
| rx_byte_i | input | 8 | Received response byte |
| tx_ready_i | input | 1 | UART accepts `tx_byte_o` |
| tx_valid_o | output | 1 | A response byte is offered |
| tx_byte_o | output | 8 | Response byte to send |
| bit_err_i | input | 1 | Bit error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| ovr_err_i | input | 1 | Overrun error pulse |
| sync_err_i | input | 1 | Sync error pulse |
| tmo_err_i | input | 1 | Frame timeout pulse |
| buf_idx_ld_i | input | 1 | Load buffer index |
| buf_idx_i | input | 3 | Index value to load |
| buf_autoinc_i | input | 1 | Advance the index after each access |
| buf_wr_i | input | 1 | Write strobe to the buffer |
| buf_wdata_i | input | 8 | Write data |
| buf_rd_i | input | 1 | Read strobe (advances the index only) |
| buf_rdata_o | output | 8 | Entry at the current index |
| id_ok_o | output | 1 | Identifier parity good |
| resp_len_o | output | 4 | Response length in bytes |
| busy_o | output | 1 | Response phase active |
| tx_ok_o | output | 1 | Transmit finished cleanly |
| rx_ok_o | output | 1 | Receive finished with a matching checksum |
| sent_cnt_o | output | 4 | Transmit bytes accepted in this frame |
| err_flags_o | output | 7 | Sticky error flags |
| err_o | output | 1 | OR of all error flags |

## Verification
The bench checks the parity rule on a corrupted identifier. A design that swaps or inverts the wrong parity bit would either accept the bad frame or reject good ones. The checksum is checked with data that produces carries, in the classic, enhanced and diagnostic-identifier cases. A design that drops the end-around carry, forgets the identifier in the enhanced sum, or uses the enhanced form on 0x3C..0x3F would send a wrong final byte. The bench also checks the length decode at every code value and at the out-of-range software lengths. It checks an abort after two transmitted bytes, where a design would keep sending or report a wrong count. Finally it checks index wrap and the write lock during a response, either of which can silently corrupt the buffer.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_RX} lin_st_e;

  localparam int unsigned NUM_ERR = 7;
  localparam int unsigned E_BIT   = 0;
  localparam int unsigned E_CKS   = 1;
  localparam int unsigned E_PAR   = 2;
  localparam int unsigned E_FRM   = 3;
  localparam int unsigned E_OVR   = 4;
  localparam int unsigned E_SYNC  = 5;
  localparam int unsigned E_TMO   = 6;

  // {bit7, bit6} of the protected identifier
  function automatic logic [1:0] lin_parity(input logic [5:0] id);
    return {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4]};
  endfunction

  // sum with end-around carry
  function automatic logic [7:0] cks_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'b0, s[8]};
  endfunction
endpackage

// File: rtl/lin_id_decode.sv
module lin_id_decode #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 2)
) (
  input  logic [7:0]       pid_i,
  input  logic             mode_v2_i,
  input  logic [CNT_W-1:0] soft_len_i,
  output logic             par_ok_o,
  output logic [CNT_W-1:0] len_o,
  output logic             classic_o
);
  import lin_resp_pkg::*;

  localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] LEN_HALF = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] LEN_QTR  = CNT_W'(DEPTH / 4);

  logic [CNT_W-1:0] len_v1;

  assign par_ok_o = (lin_parity(pid_i[5:0]) == pid_i[7:6]);

  always_comb begin
    unique case (pid_i[5:4])
      2'd3:    len_v1 = LEN_FULL;
      2'd2:    len_v1 = LEN_HALF;
      default: len_v1 = LEN_QTR;
    endcase
  end

  always_comb begin
    if (!mode_v2_i)                                     len_o = len_v1;
    else if (soft_len_i == '0 || soft_len_i > LEN_FULL) len_o = LEN_FULL;
    else                                                len_o = soft_len_i;
  end

  // diagnostic ids 0x3C..0x3F stay classic
  assign classic_o = !mode_v2_i || (pid_i[5:2] == 4'hF);
endmodule

// File: rtl/lin_resp_buf.sv
module lin_resp_buf #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_i,
  input  logic             idx_ld_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             autoinc_i,
  input  logic             sw_wr_i,
  input  logic [DW-1:0]    sw_wdata_i,
  input  logic             sw_rd_i,
  output logic [DW-1:0]    sw_rdata_o,
  input  logic             eng_wr_i,
  input  logic [IDX_W-1:0] eng_addr_i,
  input  logic [DW-1:0]    eng_wdata_i,
  output logic [DW-1:0]    eng_rdata_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [IDX_W-1:0] idx_q;
  logic             wr_ok;

  assign wr_ok       = sw_wr_i && !lock_i;
  assign sw_rdata_o  = mem_q[idx_q];
  assign eng_rdata_o = mem_q[eng_addr_i];

  // DEPTH is a power of two, so the increment wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (idx_ld_i) begin
      idx_q <= idx_i;
    end else if (autoinc_i && (wr_ok || sw_rd_i)) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (eng_wr_i) begin
      mem_q[eng_addr_i] <= eng_wdata_i;
    end else if (wr_ok) begin
      mem_q[idx_q] <= sw_wdata_i;
    end
  end
endmodule

// File: rtl/lin_resp_engine.sv
module lin_resp_engine #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 2),
  localparam int unsigned NERR  = lin_resp_pkg::NUM_ERR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_v2_i,
  input  logic             dir_tx_i,
  input  logic [CNT_W-1:0] soft_len_i,
  input  logic             id_valid_i,
  input  logic [7:0]       id_byte_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  input  logic             tx_ready_i,
  output logic             tx_valid_o,
  output logic [7:0]       tx_byte_o,
  input  logic             bit_err_i,
  input  logic             frm_err_i,
  input  logic             ovr_err_i,
  input  logic             sync_err_i,
  input  logic             tmo_err_i,
  input  logic             buf_idx_ld_i,
  input  logic [IDX_W-1:0] buf_idx_i,
  input  logic             buf_autoinc_i,
  input  logic             buf_wr_i,
  input  logic [7:0]       buf_wdata_i,
  input  logic             buf_rd_i,
  output logic [7:0]       buf_rdata_o,
  output logic             id_ok_o,
  output logic [CNT_W-1:0] resp_len_o,
  output logic             busy_o,
  output logic             tx_ok_o,
  output logic             rx_ok_o,
  output logic [CNT_W-1:0] sent_cnt_o,
  output logic [NERR-1:0]  err_flags_o,
  output logic             err_o
);
  import lin_resp_pkg::*;

  lin_st_e          st_q;
  logic [CNT_W-1:0] len_q, cnt_q, sent_q;
  logic [7:0]       acc_q;
  logic [NERR-1:0]  flags_q, err_in, cks_set;
  logic             id_ok_q, tx_ok_q, rx_ok_q;
  logic             par_ok, classic, any_err, last, eng_wr;
  logic [CNT_W-1:0] dec_len;
  logic [7:0]       eng_rdata;

  lin_id_decode #(.DEPTH(DEPTH)) u_dec (
    .pid_i      (id_byte_i),
    .mode_v2_i  (mode_v2_i),
    .soft_len_i (soft_len_i),
    .par_ok_o   (par_ok),
    .len_o      (dec_len),
    .classic_o  (classic)
  );

  lin_resp_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_i      (busy_o),
    .idx_ld_i    (buf_idx_ld_i),
    .idx_i       (buf_idx_i),
    .autoinc_i   (buf_autoinc_i),
    .sw_wr_i     (buf_wr_i),
    .sw_wdata_i  (buf_wdata_i),
    .sw_rd_i     (buf_rd_i),
    .sw_rdata_o  (buf_rdata_o),
    .eng_wr_i    (eng_wr),
    .eng_addr_i  (cnt_q[IDX_W-1:0]),
    .eng_wdata_i (rx_byte_i),
    .eng_rdata_o (eng_rdata)
  );

  always_comb begin
    err_in         = '0;
    err_in[E_BIT]  = bit_err_i;
    err_in[E_FRM]  = frm_err_i;
    err_in[E_OVR]  = ovr_err_i;
    err_in[E_SYNC] = sync_err_i;
    err_in[E_TMO]  = tmo_err_i;
  end

  assign any_err = |err_in;
  assign last    = (cnt_q == len_q);
  assign eng_wr  = (st_q == ST_RX) && rx_valid_i && !any_err && !last && !id_valid_i;

  always_comb begin
    cks_set = '0;
    cks_set[E_CKS] = (st_q == ST_RX) && rx_valid_i && !any_err && last &&
                     (rx_byte_i != ~acc_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      len_q   <= '0;
      cnt_q   <= '0;
      sent_q  <= '0;
      acc_q   <= '0;
      flags_q <= '0;
      id_ok_q <= 1'b0;
      tx_ok_q <= 1'b0;
      rx_ok_q <= 1'b0;
    end else if (id_valid_i) begin
      // a header always restarts the frame
      flags_q        <= err_in;
      flags_q[E_PAR] <= !par_ok;
      id_ok_q        <= par_ok;
      tx_ok_q        <= 1'b0;
      rx_ok_q        <= 1'b0;
      sent_q         <= '0;
      cnt_q          <= '0;
      len_q          <= dec_len;
      acc_q          <= classic ? 8'h00 : id_byte_i;
      if (!par_ok || any_err) st_q <= ST_IDLE;
      else                    st_q <= dir_tx_i ? ST_TX : ST_RX;
    end else begin
      flags_q <= flags_q | err_in | cks_set;
      unique case (st_q)
        ST_TX: begin
          if (any_err) begin
            st_q <= ST_IDLE;
          end else if (tx_ready_i) begin
            sent_q <= sent_q + CNT_W'(1);
            if (last) begin
              tx_ok_q <= 1'b1;
              st_q    <= ST_IDLE;
            end else begin
              acc_q <= cks_add(acc_q, eng_rdata);
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        ST_RX: begin
          if (any_err) begin
            st_q <= ST_IDLE;
          end else if (rx_valid_i) begin
            if (last) begin
              rx_ok_q <= (rx_byte_i == ~acc_q);
              st_q    <= ST_IDLE;
            end else begin
              acc_q <= cks_add(acc_q, rx_byte_i);
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign tx_valid_o  = (st_q == ST_TX);
  assign tx_byte_o   = last ? ~acc_q : eng_rdata;
  assign id_ok_o     = id_ok_q;
  assign resp_len_o  = len_q;
  assign tx_ok_o     = tx_ok_q;
  assign rx_ok_o     = rx_ok_q;
  assign sent_cnt_o  = sent_q;
  assign err_flags_o = flags_q;
  assign err_o       = |flags_q;
endmodule

// File: rtl/lin_resp_engine_chk.sv
module lin_resp_engine_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             id_valid_i,
  input logic             tx_ready_i,
  input logic             tx_valid_o,
  input logic             bit_err_i,
  input logic             id_ok_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] resp_len_o,
  input logic             tx_ok_o,
  input logic             rx_ok_o,
  input logic [6:0]       err_flags_o
);
  localparam logic [CNT_W-1:0] LMAX = CNT_W'(DEPTH);

  assert_id_ok_from_hdr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_ok_o) |-> $past(id_valid_i));

  assert_len_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (resp_len_o != '0) && (resp_len_o <= LMAX));

  assert_txok_on_hs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ok_o) |-> $past(tx_valid_o && tx_ready_i));

  assert_rxok_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ok_o |-> !err_flags_o[1]);

  assert_abort_tx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && bit_err_i && !id_valid_i) |=> (!tx_valid_o && err_flags_o[0]));

  assert_flags_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |=> ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o)));
endmodule

bind lin_resp_engine lin_resp_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .id_valid_i  (id_valid_i),
  .tx_ready_i  (tx_ready_i),
  .tx_valid_o  (tx_valid_o),
  .bit_err_i   (bit_err_i),
  .id_ok_o     (id_ok_o),
  .busy_o      (busy_o),
  .resp_len_o  (resp_len_o),
  .tx_ok_o     (tx_ok_o),
  .rx_ok_o     (rx_ok_o),
  .err_flags_o (err_flags_o)
);

// File: tb/lin_resp_engine_bench.sv
module lin_resp_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       mode_v2 = 0, dir_tx = 0, id_valid = 0, rx_valid = 0, tx_ready = 0;
  logic [3:0] soft_len = 0;
  logic [7:0] id_byte = 0, rx_byte = 0, wdata = 0;
  logic       bit_err = 0, frm_err = 0, ovr_err = 0, sync_err = 0, tmo_err = 0;
  logic       idx_ld = 0, autoinc = 0, wr = 0, rd = 0;
  logic [2:0] idx = 0;
  wire        tx_valid, id_ok, busy, tx_ok, rx_ok, err;
  wire [7:0]  tx_byte, rdata;
  wire [3:0]  resp_len, sent_cnt;
  wire [6:0]  flags;

  lin_resp_engine u_lin_resp_engine (
    .clk_i(clk), .rst_ni(rst_n), .mode_v2_i(mode_v2), .dir_tx_i(dir_tx),
    .soft_len_i(soft_len), .id_valid_i(id_valid), .id_byte_i(id_byte),
    .rx_valid_i(rx_valid), .rx_byte_i(rx_byte), .tx_ready_i(tx_ready),
    .tx_valid_o(tx_valid), .tx_byte_o(tx_byte), .bit_err_i(bit_err),
    .frm_err_i(frm_err), .ovr_err_i(ovr_err), .sync_err_i(sync_err),
    .tmo_err_i(tmo_err), .buf_idx_ld_i(idx_ld), .buf_idx_i(idx),
    .buf_autoinc_i(autoinc), .buf_wr_i(wr), .buf_wdata_i(wdata), .buf_rd_i(rd),
    .buf_rdata_o(rdata), .id_ok_o(id_ok), .resp_len_o(resp_len), .busy_o(busy),
    .tx_ok_o(tx_ok), .rx_ok_o(rx_ok), .sent_cnt_o(sent_cnt),
    .err_flags_o(flags), .err_o(err)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] ref_mem [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pid(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic logic [7:0] ref_cks(input logic [7:0] init, input int n);
    logic [8:0] t;
    logic [7:0] s;
    s = init;
    for (int i = 0; i < n; i++) begin
      t = {1'b0, s} + {1'b0, ref_mem[i]};
      s = t[7:0] + {7'b0, t[8]};
    end
    return ~s;
  endfunction

  task automatic header(input logic [7:0] b);
    @(negedge clk); id_byte = b; id_valid = 1;
    @(negedge clk); id_valid = 0;
  endtask

  task automatic load_idx(input logic [2:0] v);
    @(negedge clk); idx = v; idx_ld = 1;
    @(negedge clk); idx_ld = 0;
  endtask

  task automatic sw_write(input logic [7:0] v);
    @(negedge clk); wdata = v; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic fill_buf();
    ref_mem = '{8'hF0, 8'h35, 8'hC7, 8'h9A, 8'h81, 8'hFF, 8'h12, 8'h6E};
    autoinc = 1;
    load_idx(0);
    for (int i = 0; i < 8; i++) sw_write(ref_mem[i]);
    autoinc = 0;
  endtask

  // take n data bytes plus checksum, checking each
  task automatic run_tx(input string tag, input int n, input logic [7:0] cks);
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      chk({tag, " tx_valid"}, tx_valid, 1);
      chk({tag, " tx_byte"}, tx_byte, (i == n) ? cks : ref_mem[i]);
      tx_ready = 1;
      @(negedge clk); tx_ready = 0;
    end
    chk({tag, " tx_ok"}, tx_ok, 1);
    chk({tag, " busy end"}, busy, 0);
    chk({tag, " sent_cnt"}, sent_cnt, n + 1);
  endtask

  task automatic t_reset();
    chk("R8 reset flags", flags, 0);
    chk("R8 reset err", err, 0);
    chk("R1 reset id_ok", id_ok, 0);
    chk("R5 reset tx_valid", tx_valid, 0);
    chk("R5 reset busy", busy, 0);
  endtask

  task automatic t_buffer();
    fill_buf();
    autoinc = 1;
    load_idx(0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      chk("R9 autoinc read", rdata, ref_mem[i]);
      rd = 1;
      @(negedge clk); rd = 0;
    end
    #1 chk("R9 index wrap 7->0", rdata, ref_mem[0]);
    autoinc = 0;
    load_idx(3);
    @(negedge clk); rd = 1; @(negedge clk); rd = 0;
    #1 chk("R9 no autoinc holds", rdata, ref_mem[3]);
  endtask

  task automatic t_v1_tx();
    mode_v2 = 0; dir_tx = 1;
    header(pid(6'h15));
    chk("R1 id_ok good parity", id_ok, 1);
    chk("R2 len code1", resp_len, 2);
    run_tx("R4 R5 classic v1", 2, ref_cks(8'h00, 2));
    header(pid(6'h05));
    chk("R2 len code0", resp_len, 2);
    chk("R8 flags cleared by header", flags, 0);
    chk("R5 tx_ok cleared by header", tx_ok, 0);
    run_tx("R5 code0", 2, ref_cks(8'h00, 2));
    header(pid(6'h2A));
    chk("R2 len code2", resp_len, 4);
    run_tx("R5 code2", 4, ref_cks(8'h00, 4));
    header(pid(6'h3A));
    chk("R2 len code3", resp_len, 8);
    run_tx("R5 code3", 8, ref_cks(8'h00, 8));
  endtask

  task automatic t_v2_tx();
    mode_v2 = 1; dir_tx = 1;
    soft_len = 3;
    header(pid(6'h10));
    chk("R3 soft len 3", resp_len, 3);
    run_tx("R4 enhanced", 3, ref_cks(pid(6'h10), 3));
    soft_len = 8;
    header(pid(6'h3C));
    run_tx("R4 diag classic", 8, ref_cks(8'h00, 8));
    soft_len = 0;
    header(pid(6'h22));
    chk("R3 soft len 0 -> 8", resp_len, 8);
    run_tx("R4 enhanced len8", 8, ref_cks(pid(6'h22), 8));
    soft_len = 12;
    header(pid(6'h01));
    chk("R3 soft len 12 -> 8", resp_len, 8);
    run_tx("R5 len8", 8, ref_cks(pid(6'h01), 8));
  endtask

  task automatic t_rx();
    logic [7:0] d [4];
    mode_v2 = 1; dir_tx = 0; soft_len = 4;
    d = '{8'hA5, 8'hFE, 8'h03, 8'h77};
    header(pid(6'h07));
    for (int i = 0; i < 4; i++) ref_mem[i] = d[i];
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk); rx_valid = 1;
      rx_byte = (i == 4) ? ref_cks(pid(6'h07), 4) : d[i];
      @(negedge clk); rx_valid = 0;
    end
    chk("R6 rx_ok", rx_ok, 1);
    chk("R6 no cks flag", flags[1], 0);
    autoinc = 1;
    load_idx(0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk("R6 rx stored", rdata, d[i]);
      rd = 1; @(negedge clk); rd = 0;
    end
    autoinc = 0;
    header(pid(6'h07));
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk); rx_valid = 1;
      rx_byte = (i == 4) ? (ref_cks(pid(6'h07), 4) ^ 8'h01) : d[i];
      @(negedge clk); rx_valid = 0;
    end
    chk("R6 bad cks rx_ok", rx_ok, 0);
    chk("R6 R8 cks flag bit1", flags, 7'b000_0010);
    chk("R8 err summary", err, 1);
    header(pid(6'h07));
    @(negedge clk); frm_err = 1; @(negedge clk); frm_err = 0;
    chk("R7 R8 framing flag bit3", flags, 7'b000_1000);
    chk("R7 rx abort busy", busy, 0);
  endtask

  task automatic t_parity();
    mode_v2 = 1; dir_tx = 1; soft_len = 2;
    header(pid(6'h15) ^ 8'h80);
    chk("R1 bad parity id_ok", id_ok, 0);
    chk("R1 bad parity busy", busy, 0);
    chk("R1 R8 parity flag bit2", flags, 7'b000_0100);
    header(pid(6'h15) ^ 8'h40);
    chk("R1 bad p0 id_ok", id_ok, 0);
  endtask

  task automatic t_abort();
    fill_buf();
    mode_v2 = 1; dir_tx = 1; soft_len = 4;
    header(pid(6'h05));
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); tx_ready = 1; @(negedge clk); tx_ready = 0;
    end
    @(negedge clk); bit_err = 1; @(negedge clk); bit_err = 0;
    chk("R7 abort tx_valid", tx_valid, 0);
    chk("R7 sent count", sent_cnt, 2);
    chk("R7 R8 bit flag bit0", flags, 7'b000_0001);
    chk("R7 tx_ok low", tx_ok, 0);
  endtask

  task automatic t_lock();
    mode_v2 = 0; dir_tx = 1;
    header(pid(6'h15));
    load_idx(5);
    sw_write(8'hEE);
    chk("R10 busy during write", busy, 1);
    run_tx("R10 frame", 2, ref_cks(8'h00, 2));
    load_idx(5);
    #1 chk("R10 write ignored", rdata, ref_mem[5]);
  endtask

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_buffer();
    t_v1_tx();
    t_v2_tx();
    t_rx();
    t_parity();
    t_abort();
    t_lock();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule